// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the drive-level sequence for a multiplexed segment LCD with four common lines and 43 segment lines. A small bitmap memory, written through a byte-wide port, holds which segments are lit on which common. A frame-rate clock enable is divided down to a common-scan step. The block outputs one 2-bit level code per line. An external resistor ladder and pad drivers turn each code into a voltage. The block only chooses the codes.

Three drive schemes can be selected: 1/2 bias with two commons, 1/3 bias with three commons, and 1/3 bias with four commons. Every second frame is the first frame with each level code mirrored (code XOR 3). The long-term average voltage across every cell is therefore zero. A blank control turns every segment off but keeps the scan and the polarity timing running. This lets the frame clock source be changed without visible flicker. With the mode field at zero, or during reset, every line sits at ground.

A three-state controller governs the sequence:
- ST_OFF: stopped, and the timing is cleared.
- ST_RUN: scanning and showing the bitmap.
- ST_BLANK: scanning with all segments off.

Its transitions are:
- start: ST_OFF to ST_RUN or ST_BLANK, when the mode becomes non-zero.
- blank: ST_RUN to ST_BLANK, when the blank control is set.
- unblank: ST_BLANK to ST_RUN, when the blank control is cleared.
- stop: ST_RUN or ST_BLANK to ST_OFF, when the mode returns to zero.

Each transition takes effect at the next clock edge.

Top module: `lcd_mux_seq`

## Requirements
- R1: While rst_n is low, every common and segment code is V0 (code 0), whatever the other inputs are.
- R2: With mode_sel = 00, every output code is V0, and the scan timing is cleared. After mode_sel becomes non-zero, the first edge enters the scan state. Counting starts from common 0, in the positive frame.
- R3: A scan step happens after every 2^(fp_sel+7) clock cycles in which frame_tick is high. The first clock edge after start is not counted, and cycles with frame_tick low are not counted.
- R4: mode_sel 01 scans 2 commons, 10 scans 3 and 11 scans 4. Commons are selected in the order 0, 1, ... N-1 and then wrap to 0. The polarity flips at each wrap, so frames alternate between positive and inverted.
- R5: In the positive frame the selected common is V3 (code 3), and every other common (including any unused one) is V1 (code 1). In the inverted frame each code is mirrored: V0 and V2.
- R6: In the positive frame a lit segment is V0. An unlit segment is V2 under 1/3 bias (mode 10 or 11) and V1 under 1/2 bias (mode 01). In the inverted frame every segment code is mirrored (XOR 3).
- R7: While blank_en is high and the mode is non-zero, every segment is treated as unlit. The commons keep scanning, and the step and polarity timing is unchanged across a blank change.
- R8: The byte written at address 0x64+k holds segment 2k in bits 3:0 and segment 2k+1 in bits 7:4, with bit i of each nibble lighting that segment on common i. Segment 42 is bits 3:0 of address 0x79. The bitmap resets to all unlit.
- R9: Writes to addresses outside 0x64..0x79 change nothing that is displayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame-rate clock enable |
| wr_en | input | 1 | Bitmap write strobe |
| wr_addr | input | 8 | Bitmap byte address |
| wr_data | input | 8 | Bitmap byte value |
| mode_sel | input | 2 | 00 stop, 01 1/2 duty, 10 1/3 duty, 11 1/4 duty |
| blank_en | input | 1 | Turn all segments off, keep timing |
| fp_sel | input | 2 | Step divide exponent offset (2^(fp_sel+7)) |
| com_lvl | output | 8 | Level code of common i in bits [2i+1:2i] |
| seg_lvl | output | 86 | Level code of segment s in bits [2s+1:2s] |

## Verification
The directed runs use each of the three modes against a sparse bitmap and a random bitmap, over at least two complete frames. They separate the common count and wrap point of each mode, the 1/2-bias versus 1/3-bias unlit level, and the mirrored second frame. Samples are taken on both sides of each step edge, at the slowest and fastest divide settings, and random gating of the frame enable runs alongside them. Together these expose an off-by-one in the divider, or counting of cycles in which the enable is low. A blank run, and a run that toggles blank midway, show that segments go dark without shifting the scan phase. Writes just outside the address window, and a sparse pattern on the first and last bytes, pin down the nibble-to-segment mapping and the window bounds.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam logic [1:0] LV0 = 2'd0;
    localparam logic [1:0] LV1 = 2'd1;
    localparam logic [1:0] LV2 = 2'd2;
    localparam logic [1:0] LV3 = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_BLANK = 2'd2
    } seq_state_e;

    // number of commons scanned for a mode code
    function automatic logic [2:0] scan_count(input logic [1:0] mode);
        logic [2:0] n;
        case (mode)
            2'b01:   n = 3'd2;
            2'b10:   n = 3'd3;
            2'b11:   n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

    // inverted frame mirrors the level code
    function automatic logic [1:0] flip(input logic [1:0] v, input logic inv);
        return inv ? ~v : v;
    endfunction

endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
    parameter int NSEG = 43,
    parameter int NCOM = 4,
    parameter int AW = 8,
    parameter int BASE_ADDR = 'h64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    output logic [NSEG*NCOM-1:0] seg_bits
);
    localparam int SEG_PER_BYTE = 8 / NCOM;
    localparam int NBYTES = (NSEG + SEG_PER_BYTE - 1) / SEG_PER_BYTE;
    localparam int NBITS = NSEG * NCOM;

    logic [NBITS-1:0] mem_q;
    logic             in_win;
    logic [AW-1:0]    offset;

    always_comb begin
        in_win = (32'(wr_addr) >= BASE_ADDR) && (32'(wr_addr) < BASE_ADDR + NBYTES);
        offset = AW'(32'(wr_addr) - BASE_ADDR);
    end

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[b] <= 1'b0;
            end else if (wr_en && in_win && (32'(offset) == b / 8)) begin
                mem_q[b] <= wr_data[b % 8];
            end
        end
    end

    assign seg_bits = mem_q;

    // R9: stray writes leave the bitmap untouched
    p_ignore_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_win) |=> $stable(mem_q));

endmodule

// File: rtl/lcd_frame_div.sv
module lcd_frame_div #(
    parameter int PRE_BASE = 7,
    parameter int FPW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  logic [FPW-1:0] fp,
    output logic           step
);
    localparam int CW = PRE_BASE + (1 << FPW) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = CW'((64'd1 << (PRE_BASE + int'(fp))) - 64'd1);
        step   = run && tick && (cnt_q >= lim_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= step ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: idle enable cycles do not advance the divider
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

    // R2: a stopped sequencer restarts from a cleared divider
    p_clear_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_seq_pkg::*;
#(
    parameter int NCOM = 4,
    localparam int IW = $clog2(NCOM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          blank,
    input  logic          step,
    output seq_state_e    state,
    output logic [IW-1:0] idx,
    output logic          pol,
    output logic          active,
    output logic          blank_on
);
    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          pol_q;
    logic [2:0]    ncom;
    logic          last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode != 2'b00) state_d = blank ? ST_BLANK : ST_RUN;
            end
            ST_RUN: begin
                if (mode == 2'b00) state_d = ST_OFF;
                else if (blank)    state_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (mode == 2'b00) state_d = ST_OFF;
                else if (!blank)   state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        ncom = scan_count(mode);
        last = (32'(idx_q) + 1) >= 32'(ncom);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_OFF) begin
            idx_q <= '0;
            pol_q <= 1'b0;
        end else if (step) begin
            if (last) begin
                idx_q <= '0;
                pol_q <= ~pol_q;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        active   = 1'b0;
        blank_on = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_RUN:   active = 1'b1;
            ST_BLANK: begin
                active   = 1'b1;
                blank_on = 1'b1;
            end
            default:  ;
        endcase
    end

    assign state = state_q;
    assign idx   = idx_q;
    assign pol   = pol_q;

    // R4: scan position and polarity move only on a step
    p_hold_between_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && !step) |=> ($stable(idx_q) && $stable(pol_q)));

    // R4: wrap from the last common flips the frame polarity
    p_wrap_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && step && last) |=> (idx_q == '0 && pol_q != $past(pol_q)));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_seq_pkg::*;
#(
    parameter int NCOM = 4,
    parameter int NSEG = 43,
    localparam int IW = $clog2(NCOM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 blank_on,
    input  logic                 third,
    input  logic [2:0]           ncom,
    input  logic [IW-1:0]        idx,
    input  logic                 pol,
    input  logic [NSEG*NCOM-1:0] seg_bits,
    output logic [NCOM*2-1:0]    com_lvl,
    output logic [NSEG*2-1:0]    seg_lvl
);
    logic          idx_ok;
    logic [NCOM-1:0] com_ext;
    logic [NSEG-1:0] seg_ext;

    assign idx_ok = 32'(idx) < 32'(ncom);

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        logic sel;
        always_comb begin
            sel = idx_ok && (32'(idx) == c);
            if (!active) com_lvl[c*2 +: 2] = LV0;
            else         com_lvl[c*2 +: 2] = flip(sel ? LV3 : LV1, pol);
        end
        assign com_ext[c] = (com_lvl[c*2 +: 2] == LV0) || (com_lvl[c*2 +: 2] == LV3);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic [NCOM-1:0] nib;
        logic            lit;
        always_comb begin
            nib = seg_bits[s*NCOM +: NCOM];
            lit = !blank_on && idx_ok && nib[idx];
            if (!active)  seg_lvl[s*2 +: 2] = LV0;
            else if (lit) seg_lvl[s*2 +: 2] = flip(LV0, pol);
            else          seg_lvl[s*2 +: 2] = flip(third ? LV2 : LV1, pol);
        end
        assign seg_ext[s] = (seg_lvl[s*2 +: 2] == LV0) || (seg_lvl[s*2 +: 2] == LV3);
    end

    // R5: exactly one common sits at a select level while scanning
    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && idx_ok) |-> ($countones(com_ext) == 1));

    // R7: no segment is driven to a lit level while blanked
    p_blank_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_on |-> (seg_ext == '0));

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int NCOM = 4,
    parameter int NSEG = 43,
    parameter int AW = 8,
    parameter int BASE_ADDR = 'h64,
    parameter int PRE_BASE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        mode_sel,
    input  logic              blank_en,
    input  logic [1:0]        fp_sel,
    output logic [NCOM*2-1:0] com_lvl,
    output logic [NSEG*2-1:0] seg_lvl
);
    localparam int IW = $clog2(NCOM);

    logic [NSEG*NCOM-1:0] seg_bits;
    logic                 step;
    seq_state_e           state;
    logic [IW-1:0]        idx;
    logic                 pol;
    logic                 active;
    logic                 blank_on;
    logic                 third;
    logic [2:0]           ncom;

    assign third = (mode_sel != 2'b01);
    assign ncom  = scan_count(mode_sel);

    lcd_disp_ram #(
        .NSEG(NSEG), .NCOM(NCOM), .AW(AW), .BASE_ADDR(BASE_ADDR)
    ) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seg_bits(seg_bits)
    );

    lcd_frame_div #(
        .PRE_BASE(PRE_BASE), .FPW(2)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(frame_tick),
        .fp(fp_sel), .step(step)
    );

    lcd_scan_fsm #(
        .NCOM(NCOM)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode_sel), .blank(blank_en),
        .step(step), .state(state), .idx(idx), .pol(pol),
        .active(active), .blank_on(blank_on)
    );

    lcd_level_map #(
        .NCOM(NCOM), .NSEG(NSEG)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .active(active), .blank_on(blank_on),
        .third(third), .ncom(ncom), .idx(idx), .pol(pol),
        .seg_bits(seg_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // R2: a stopped sequencer drives every line to ground
    p_off_ground_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (com_lvl == '0 && seg_lvl == '0));

endmodule

// File: tb/lcd_mux_seq_test.sv
module lcd_mux_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCOM = 4;
    localparam int NSEG = 43;
    localparam int NBYTES = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] mode_sel = 2'b00;
    logic blank_en = 1'b0;
    logic [1:0] fp_sel = 2'b00;
    logic [NCOM*2-1:0] com_lvl;
    logic [NSEG*2-1:0] seg_lvl;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] ram_m [NBYTES];
    logic [1:0] mode_m = 2'b00;
    bit blank_m = 1'b0;
    int fp_m = 0;
    int counted = 0;
    int ecount = 0;

    lcd_mux_seq uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode_sel(mode_sel),
        .blank_en(blank_en), .fp_sel(fp_sel), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ncount(input logic [1:0] m);
        return (m == 2'b00) ? 0 : int'(m) + 1;
    endfunction

    function automatic logic [1:0] mir(input logic [1:0] v, input bit p);
        return p ? ~v : v;
    endfunction

    function automatic logic [NCOM*2-1:0] exp_com();
        logic [NCOM*2-1:0] r = '0;
        int n = ncount(mode_m);
        if (n != 0) begin
            int s = counted / (1 << (fp_m + 7));
            int ix = s % n;
            bit p = ((s / n) % 2) == 1;
            for (int c = 0; c < NCOM; c++)
                r[c*2 +: 2] = mir((c == ix) ? 2'd3 : 2'd1, p);
        end
        return r;
    endfunction

    function automatic logic [NSEG*2-1:0] exp_seg();
        logic [NSEG*2-1:0] r = '0;
        int n = ncount(mode_m);
        if (n != 0) begin
            int s = counted / (1 << (fp_m + 7));
            int ix = s % n;
            bit p = ((s / n) % 2) == 1;
            for (int g = 0; g < NSEG; g++) begin
                logic [7:0] by = ram_m[g / 2];
                logic [3:0] nb = (g % 2 == 1) ? by[7:4] : by[3:0];
                bit lit = !blank_m && nb[ix];
                r[g*2 +: 2] = mir(lit ? 2'd0 : ((mode_m == 2'b01) ? 2'd1 : 2'd2), p);
            end
        end
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [NCOM*2-1:0] ec = exp_com();
        logic [NSEG*2-1:0] es = exp_seg();
        n_checks++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_fail++;
            $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", tag, com_lvl, seg_lvl, ec, es);
        end
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a >= 8'h64 && a <= 8'h79) ram_m[a - 8'h64] = d;
    endtask

    task automatic run_cfg(input logic [1:0] m, input bit b, input int f,
                           input bit gate, input int ncyc, input string tag, input bit flipb);
        mode_sel = 2'b00; mode_m = 2'b00; frame_tick = 1'b1; counted = 0;
        @(negedge clk); @(negedge clk);
        check_all("R2");
        mode_sel = m; mode_m = m; blank_en = b; blank_m = b;
        fp_sel = 2'(f); fp_m = f; ecount = 0; counted = 0;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            ecount++;
            if (ecount >= 2 && frame_tick) counted++;
            if (c % 16 == 0 || c % 16 == 1) begin
                check_all(tag);
                if (flipb && c == ((ncyc / 2) / 16) * 16) begin
                    blank_en = ~blank_en; blank_m = ~blank_m;
                end
            end
            if (gate) frame_tick = ($urandom % 4) != 0;
        end
        frame_tick = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NBYTES; k++) ram_m[k] = 8'h00;
        // R1: reset dominates a non-zero mode
        mode_sel = 2'b11;
        repeat (3) @(negedge clk);
        check_all("R1");
        mode_sel = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R8: first and last bytes of the window
        write_byte(8'h64, 8'h84);
        write_byte(8'h79, 8'hFF);
        check_all("R2");
        run_cfg(2'b11, 1'b0, 0, 1'b0, 2*4*128 + 64, "R8", 1'b0);

        // R9: addresses just outside the window
        write_byte(8'h63, 8'hFF);
        write_byte(8'h7A, 8'hFF);
        write_byte(8'h00, 8'hFF);
        write_byte(8'hFF, 8'hFF);
        run_cfg(2'b11, 1'b0, 0, 1'b0, 2*4*128 + 64, "R9", 1'b0);

        for (int k = 0; k < NBYTES; k++) write_byte(8'(8'h64 + k), 8'($urandom));

        run_cfg(2'b01, 1'b0, 0, 1'b0, 2*2*128 + 64, "R6", 1'b0);
        run_cfg(2'b10, 1'b0, 1, 1'b0, 2*3*256 + 64, "R5", 1'b0);
        run_cfg(2'b11, 1'b0, 0, 1'b0, 2*4*128 + 64, "R4", 1'b0);
        run_cfg(2'b11, 1'b1, 0, 1'b0, 2*4*128 + 64, "R7", 1'b0);
        run_cfg(2'b10, 1'b0, 0, 1'b0, 2*3*128 + 64, "R7", 1'b1);
        run_cfg(2'b11, 1'b0, 3, 1'b0, 2*4*1024 + 64, "R3", 1'b0);

        for (int t = 0; t < 6; t++) begin
            logic [1:0] m = 2'(($urandom % 3) + 1);
            int f = $urandom % 2;
            bit b = ($urandom % 4) == 0;
            for (int k = 0; k < NBYTES; k++) write_byte(8'(8'h64 + k), 8'($urandom));
            run_cfg(m, b, f, 1'b1, (2 * ncount(m) * (128 << f) * 4) / 3 + 64, "R3", 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule